// File: doc/BRIEF.md
# Ethernet Frame Transmit Sequencer

This block turns a caller-supplied byte stream into a complete IEEE 802.3 frame, ready for the MII/RMII adapter. The caller sends the destination address, the source address, the length/type field and the data as one stream. The sequencer wraps that stream with the framing the caller does not supply. Ahead of the first caller byte it sends a run of preamble bytes and a start-of-frame delimiter. Short frames get zero bytes added to reach the legal minimum. After the last byte it appends a 32-bit CRC frame check sequence.

Both sides use valid/ready handshakes. The input carries a last-byte marker and the output carries start-of-frame and end-of-frame markers. Caller bytes pass straight through to the output with no buffering, so a stall on either side reaches the other side in the same cycle. While the sequencer is producing bytes of its own, it holds its input ready low. Once the final check-sequence byte is accepted, the block goes idle and waits for the next input byte to be offered.

Top module: `eth_tx_framer`

## Requirements
- R1: When a byte is offered while idle, exactly PRE_LEN (default 7) bytes of value 0x55 are output first, and out_sof is high only on the first of them.
- R2: The byte after the preamble is the delimiter 0xD5.
- R3: After the delimiter, every accepted input byte appears on the output unchanged and in order, and nothing is emitted while the caller holds in_valid low.
- R4: When the caller stream (address through data) is shorter than MIN_BODY (default 60) bytes, 0x00 bytes follow it until MIN_BODY bytes have been sent after the delimiter.
- R5: When the caller stream is MIN_BODY bytes or longer, no pad byte is inserted.
- R6: Four check bytes follow the body. They hold the bitwise inverse of a CRC-32 that uses polynomial 0x04C11DB7 with reflected input, initial value 0xFFFFFFFF and no pre-shift, computed over every byte after the delimiter and before the check sequence. They are sent least significant byte first, so running the same register over body plus check bytes leaves 0xDEBB20E3.
- R7: out_eof is high only on the last check-sequence byte, and out_sof only on the first preamble byte.
- R8: in_ready is low during preamble, delimiter, pad and check-sequence bytes and in idle, and is never high while out_ready is low.
- R9: While a generated byte (preamble, delimiter, pad or check) is stalled by out_ready low, out_valid stays high and out_data keeps its value.
- R10: After reset, and after the accepted last check byte, out_valid and in_ready stay low until a new input byte is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Caller byte is present |
| in_ready | output | 1 | Caller byte is taken this cycle when in_valid is high |
| in_data | input | 8 | Caller byte (address, type or data) |
| in_last | input | 1 | Marks the final caller byte of a frame |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Frame byte toward the adapter |
| out_sof | output | 1 | High on the first preamble byte |
| out_eof | output | 1 | High on the last check-sequence byte |

## Verification
A wrong phase or counter value shows up at the ports on the very next accepted output byte. Such a fault produces a preamble of the wrong length, a missing delimiter, a misplaced pad run or a misplaced end marker, and each of these breaks the byte-for-byte comparison against the expected frame. A corrupted CRC register shows nothing until the check bytes at the end of the frame. There, both the expected-value comparison and the residue test catch it. A broken stall path shows in the cycle after the stall: the held byte changes, or in_ready rises while the sequencer is still producing bytes of its own.

// File: rtl/eth_tx_pkg.sv
// Shared types, constants and the CRC step function for the transmit sequencer.
// Assumes byte-wide data and the reflected Ethernet CRC-32 convention.
package eth_tx_pkg;

    // Phases of one frame transmission, in transmit order.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_SFD  = 3'd2,
        PH_BODY = 3'd3,
        PH_PAD  = 3'd4,
        PH_FCS  = 3'd5
    } tx_phase_e;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [7:0]  PAD_BYTE      = 8'h00;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam int          FCS_BYTES     = 4;

    // Advance a reflected CRC-32 register by one byte, LSB of the byte first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
// CRC-32 accumulator for the frame check sequence.
// Reloads the seed on clear; folds one byte per cycle when step is high.
// Assumes clear and step are never high in the same cycle.
module eth_tx_crc32
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    // Hold the running CRC; seed on reset or clear, fold a byte on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (clear) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            crc_q <= crc32_byte(crc_q, din);
        end
    end

    // R6
    crc_seeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/eth_tx_seq_ctrl.sv
// Phase sequencer: walks idle, preamble, delimiter, body, pad and check phases
// and keeps the byte counters for each phase.
// Assumes the caller holds in_last with its final byte and PRE_LEN >= 1, MIN_BODY >= 1.
module eth_tx_seq_ctrl
    import eth_tx_pkg::*;
#(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic            out_ready,
    output tx_phase_e       phase,
    output logic            pre_first,
    output logic [1:0]      fcs_idx,
    output logic            fcs_final
);

    localparam int PRE_W  = $clog2(PRE_LEN + 1);
    localparam int BODY_W = $clog2(MIN_BODY + 1);
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRE_LEN - 1);
    localparam logic [PRE_W-1:0]  PRE_FULL  = PRE_W'(PRE_LEN);
    localparam logic [BODY_W-1:0] BODY_LAST = BODY_W'(MIN_BODY - 1);
    localparam logic [BODY_W-1:0] BODY_MIN  = BODY_W'(MIN_BODY);
    localparam logic [1:0]        FCS_LAST  = 2'(FCS_BYTES - 1);

    tx_phase_e         phase_q, phase_d;
    logic [PRE_W-1:0]  pre_cnt_q, pre_cnt_d;
    logic [BODY_W-1:0] body_cnt_q, body_cnt_d;
    logic [1:0]        fcs_cnt_q, fcs_cnt_d;
    logic              body_take;

    assign body_take = (phase_q == PH_BODY) && in_valid && out_ready;

    // Next-phase and counter logic for one frame.
    always_comb begin
        phase_d    = phase_q;
        pre_cnt_d  = pre_cnt_q;
        body_cnt_d = body_cnt_q;
        fcs_cnt_d  = fcs_cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (in_valid) begin
                    phase_d   = PH_PRE;
                    pre_cnt_d = '0;
                end
            end
            PH_PRE: begin
                if (out_ready) begin
                    pre_cnt_d = pre_cnt_q + 1'b1;
                    if (pre_cnt_q == PRE_LAST) begin
                        phase_d = PH_SFD;
                    end
                end
            end
            PH_SFD: begin
                if (out_ready) begin
                    phase_d    = PH_BODY;
                    body_cnt_d = '0;
                end
            end
            PH_BODY: begin
                if (body_take) begin
                    if (body_cnt_q < BODY_MIN) begin
                        body_cnt_d = body_cnt_q + 1'b1;
                    end
                    if (in_last) begin
                        fcs_cnt_d = '0;
                        phase_d   = (body_cnt_q < BODY_LAST) ? PH_PAD : PH_FCS;
                    end
                end
            end
            PH_PAD: begin
                if (out_ready) begin
                    body_cnt_d = body_cnt_q + 1'b1;
                    if (body_cnt_q == BODY_LAST) begin
                        phase_d = PH_FCS;
                    end
                end
            end
            PH_FCS: begin
                if (out_ready) begin
                    fcs_cnt_d = fcs_cnt_q + 1'b1;
                    if (fcs_cnt_q == FCS_LAST) begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Register the phase and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            pre_cnt_q  <= '0;
            body_cnt_q <= '0;
            fcs_cnt_q  <= '0;
        end else begin
            phase_q    <= phase_d;
            pre_cnt_q  <= pre_cnt_d;
            body_cnt_q <= body_cnt_d;
            fcs_cnt_q  <= fcs_cnt_d;
        end
    end

    assign phase     = phase_q;
    assign pre_first = (phase_q == PH_PRE) && (pre_cnt_q == '0);
    assign fcs_idx   = fcs_cnt_q;
    assign fcs_final = (phase_q == PH_FCS) && (fcs_cnt_q == FCS_LAST);

    // Checker count: accepted preamble bytes since the last idle.
    logic [PRE_W-1:0] pre_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || phase_q == PH_IDLE) begin
            pre_seen_q <= '0;
        end else if (phase_q == PH_PRE && out_ready) begin
            pre_seen_q <= pre_seen_q + 1'b1;
        end
    end

    // R1
    pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SFD) |-> (pre_seen_q == PRE_FULL));

    // R4
    pad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PAD) |-> (body_cnt_q < BODY_MIN));

    // R5
    no_pad_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BODY && body_cnt_q >= BODY_LAST) |=> (phase_q != PH_PAD));

endmodule

// File: rtl/eth_tx_framer.sv
// Top of the transmit sequencer: wraps a caller byte stream with preamble,
// delimiter, zero padding and CRC-32 check sequence.
// Assumes the downstream honours valid/ready; body bytes pass through unbuffered.
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof
);

    tx_phase_e   phase;
    logic        pre_first;
    logic [1:0]  fcs_idx;
    logic        fcs_final;
    logic [31:0] crc_q;
    logic [31:0] fcs_word;
    logic        crc_step;
    logic [7:0]  crc_din;

    eth_tx_seq_ctrl #(
        .PRE_LEN  (PRE_LEN),
        .MIN_BODY (MIN_BODY)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .out_ready (out_ready),
        .phase     (phase),
        .pre_first (pre_first),
        .fcs_idx   (fcs_idx),
        .fcs_final (fcs_final)
    );

    // Fold body and pad bytes into the CRC as they are accepted downstream.
    always_comb begin
        crc_step = 1'b0;
        crc_din  = PAD_BYTE;
        if (phase == PH_BODY) begin
            crc_step = in_valid && out_ready;
            crc_din  = in_data;
        end else if (phase == PH_PAD) begin
            crc_step = out_ready;
        end
    end

    eth_tx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase == PH_IDLE),
        .step  (crc_step),
        .din   (crc_din),
        .crc_q (crc_q)
    );

    assign fcs_word = ~crc_q;

    // Select the output byte and handshakes for the current phase.
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        in_ready  = 1'b0;
        unique case (phase)
            PH_PRE: begin
                out_valid = 1'b1;
                out_data  = PRE_BYTE;
            end
            PH_SFD: begin
                out_valid = 1'b1;
                out_data  = SFD_BYTE;
            end
            PH_BODY: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
            end
            PH_PAD: begin
                out_valid = 1'b1;
                out_data  = PAD_BYTE;
            end
            PH_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_word[fcs_idx*8 +: 8];
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign out_sof = pre_first;
    assign out_eof = fcs_final;

    // R8
    in_ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (out_ready && (out_valid == in_valid)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !in_ready && phase != PH_BODY)
            |=> (out_valid && $stable(out_data)));

    // R7
    sof_marks_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_data == PRE_BYTE));

    // R10
    idle_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && out_valid && out_ready) |=> (!out_valid && !in_ready));

endmodule

// File: tb/eth_tx_framer_tb.sv
// Sweep of caller lengths 1..70 under varied input gaps and output stalls,
// comparing every output byte with a frame built arithmetically in the bench.
module eth_tx_framer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] exp_b [0:127];
    logic [7:0] rx_b  [0:127];
    int exp_n;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eth_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Bit-serial reflected CRC-32 register update.
    function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in;
        for (int j = 0; j < 8; j++) begin
            c = (c >> 1) ^ ((c[0] ^ b[j]) ? 32'hEDB88320 : 32'h0);
        end
        return c;
    endfunction

    function automatic logic [7:0] pay_byte(input int len, input int i);
        return 8'((len * 7 + i * 13 + 3) & 255);
    endfunction

    task automatic build_frame(input int len);
        int bl;
        logic [31:0] c;
        bl = (len < 60) ? 60 : len;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < bl; i++) begin
            exp_b[8 + i] = (i < len) ? pay_byte(len, i) : 8'h00;
            c = ref_crc(c, exp_b[8 + i]);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) exp_b[8 + bl + i] = c[8*i +: 8];
        exp_n = 12 + bl;
    endtask

    function automatic string region(input int k, input int len);
        if (k < 7) return "R1";
        if (k == 7) return "R2";
        if (k < 8 + len) return "R3";
        if (k < exp_n - 4) return "R4";
        return "R6";
    endfunction

    task automatic drive(input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            bit taken;
            taken = 1'b0;
            while (!taken) begin
                @(negedge clk);
                in_valid = !(gap != 0 && (cyc % 4) == 1);
                in_data  = pay_byte(len, i);
                in_last  = (i == len - 1);
                #2;
                taken = in_valid && in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic monitor(input int len, input int rmode);
        int k;
        bit prev_stall;
        logic [7:0] prev_data;
        k = 0;
        prev_stall = 1'b0;
        prev_data = 8'h00;
        while (k < exp_n) begin
            @(negedge clk);
            out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) != 0) : ((cyc % 5) < 2);
            #1;
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R9", {out_valid, out_data}, {1'b1, prev_data});
            if (out_valid && (k < 8 || k >= 8 + len))
                check(!in_ready, "R8", in_ready, 0);
            if (!out_ready)
                check(!in_ready, "R8", in_ready, 0);
            if (out_valid && out_ready) begin
                check(out_data == exp_b[k], region(k, len), out_data, exp_b[k]);
                check(out_sof == (k == 0), "R7", out_sof, k == 0);
                check(out_eof == (k == exp_n - 1), "R7", out_eof, k == exp_n - 1);
                if (len >= 60 && k >= 8 + len && k < exp_n - 4)
                    check(1'b0, "R5", k, 8 + len);
                rx_b[k] = out_data;
                k++;
                prev_stall = 1'b0;
            end else begin
                prev_stall = out_valid && !out_ready && (k < 8 || k >= 8 + len);
                prev_data = out_data;
            end
            @(posedge clk);
        end
    endtask

    task automatic residue_check();
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 8; i < exp_n; i++) c = ref_crc(c, rx_b[i]);
        check(c == 32'hDEBB20E3, "R6", c, 32'hDEBB20E3);
    endtask

    task automatic idle_check();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            check(!out_valid && !in_ready, "R10", {out_valid, in_ready}, 0);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !in_ready && !out_sof && !out_eof, "R10",
              {out_valid, in_ready, out_sof, out_eof}, 0);
        rst_n = 1'b1;
        idle_check();
        for (int len = 1; len <= 70; len++) begin
            build_frame(len);
            fork
                drive(len, len % 2);
                monitor(len, len % 3);
            join
            residue_check();
            idle_check();
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule